// File: doc/BRIEF.md
# Aliased Atomic Register Bank

This block is a small bank of 32-bit registers on a plain memory-mapped bus. Each register can be reached through four address windows of 4 kB. All four reach the same storage, and each one applies a different write operation. The first window replaces the value. The second inverts the bits given in the write data. The third sets those bits, and the fourth clears them. Because of this, software can flip, raise or drop single flag bits with one bus write, without first reading the register. A concurrent writer therefore cannot slip in between a read and a write.

Address bits [13:12] choose the operation and bits [11:2] choose the register word. Bits [1:0] are ignored. The read-modify-write happens inside the clock edge that accepts the write. A read through any window returns the stored value on the next cycle, flagged by a one-cycle valid pulse. The bus has no back-pressure: every strobe is accepted in the cycle it is high, so the block never stalls a requester.

Top module: `alias_regbank`

## Requirements
- R1: A synchronous active-high reset sets every register to zero, sets `bus_rdata` to zero and holds `bus_rvalid` low.
- R2: A write with address bits [13:12] = 0 replaces the addressed register with `bus_wdata`.
- R3: A write with address bits [13:12] = 1 sets the register to its old value XOR `bus_wdata`.
- R4: A write with address bits [13:12] = 2 sets the register to its old value OR `bus_wdata`.
- R5: A write with address bits [13:12] = 3 sets the register to its old value AND NOT `bus_wdata`.
- R6: A read through any of the four windows returns the stored value and leaves the register unchanged.
- R7: Address bits [11:2] give the register index. An index of `NUM_REGS` or more reads as zero, and a write to it changes no register.
- R8: `bus_rvalid` is high exactly in the cycle after a cycle with `bus_rd` high, and `bus_rdata` then holds the value read. Without a read, `bus_rdata` keeps its last value.
- R9: A read and a write in the same cycle return the value from before that write. Writes in consecutive cycles each act on the result of the one before.
- R10: Address bits [1:0] have no effect on which register is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_addr | input | 14 | Byte address: [13:12] operation window, [11:2] register index |
| bus_wdata | input | 32 | Write data, or the bit mask for the XOR, set and clear windows |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | High for one cycle when `bus_rdata` carries a read result |

## Verification
A write takes effect at the clock edge that accepts it. A read in any following cycle therefore sees the new value. Read data arrives one edge after the read strobe, so the bench drives each access on a falling edge and samples `bus_rdata` and `bus_rvalid` shortly after the next rising edge. The same-cycle read/write case is sampled at that same point and is expected to show the old value. The bound checker states the one-cycle latency directly, together with the value relations across a write followed by a read.

// File: rtl/alias_regbank_pkg.sv
package alias_regbank_pkg;
  localparam int ADDR_W   = 14;
  localparam int ALIAS_LSB = 12;
  localparam int IDX_LSB  = 2;
  localparam int IDX_W    = ALIAS_LSB - IDX_LSB;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_FLIP  = 2'd1,
    OP_RAISE = 2'd2,
    OP_DROP  = 2'd3
  } alias_op_e;
endpackage

// File: rtl/alias_decode.sv
module alias_decode
  import alias_regbank_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic [ADDR_W-1:IDX_LSB] addr_word,
  output alias_op_e               op,
  output logic [IDX_W-1:0]        idx,
  output logic                    hit
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_REGS);

  always_comb begin
    op  = alias_op_e'(addr_word[ADDR_W-1:ALIAS_LSB]);
    idx = addr_word[ALIAS_LSB-1:IDX_LSB];
    hit = ({1'b0, idx} < LIMIT);
  end
endmodule

// File: rtl/alias_rmw.sv
module alias_rmw
  import alias_regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alias_op_e         op,
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] nxt
);
  always_comb begin
    unique case (op)
      OP_WRITE: nxt = wdata;
      OP_FLIP:  nxt = cur ^ wdata;
      OP_RAISE: nxt = cur | wdata;
      OP_DROP:  nxt = cur & ~wdata;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/alias_regbank.sv
module alias_regbank
  import alias_regbank_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [13:0]       bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  alias_op_e         op;
  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic [DATA_W-1:0] cur;
  logic [DATA_W-1:0] nxt;
  logic [DATA_W-1:0] q [NUM_REGS];
  logic              unused_addr_lsbs;

  assign unused_addr_lsbs = ^bus_addr[IDX_LSB-1:0];

  alias_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .addr_word (bus_addr[ADDR_W-1:IDX_LSB]),
    .op        (op),
    .idx       (idx),
    .hit       (hit)
  );

  // shared selection feeds both the read path and the modify step
  always_comb begin
    cur = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit && idx == IDX_W'(i)) cur = q[i];
    end
  end

  alias_rmw #(.DATA_W(DATA_W)) u_rmw (
    .op    (op),
    .cur   (cur),
    .wdata (bus_wdata),
    .nxt   (nxt)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic we;
    assign we = bus_wr && hit && (idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst)     q[g] <= '0;
      else if (we) q[g] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= cur;
    end
  end
endmodule

// File: rtl/alias_regbank_chk.sv
module alias_regbank_chk #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [13:0]       bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid
);
  logic [9:0] w_idx;
  logic       in_range;
  logic [1:0] win;
  assign w_idx    = bus_addr[11:2];
  assign win      = bus_addr[13:12];
  assign in_range = ({1'b0, w_idx} < 11'(NUM_REGS));

  p_reset_r1: assert property (@(posedge clk) rst |=> (!bus_rvalid && bus_rdata == '0));

  p_rvalid_on_read_r8: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  p_rvalid_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  p_oor_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !in_range) |=> bus_rdata == '0);

  p_plain_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && in_range && !$past(rst) && $past(bus_wr) && $past(win) == 2'd0
     && $past(w_idx) == w_idx) |=> bus_rdata == $past(bus_wdata, 2));

  p_set_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && in_range && !$past(rst) && $past(bus_wr) && $past(win) == 2'd2
     && $past(w_idx) == w_idx) |=> (bus_rdata & $past(bus_wdata, 2)) == $past(bus_wdata, 2));

  p_clear_bits_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && in_range && !$past(rst) && $past(bus_wr) && $past(win) == 2'd3
     && $past(w_idx) == w_idx) |=> (bus_rdata & $past(bus_wdata, 2)) == '0);
endmodule

bind alias_regbank alias_regbank_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid)
);

// File: tb/alias_regbank_tb.sv
module alias_regbank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  alias_regbank #(.NUM_REGS(8), .DATA_W(32)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [13:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 14'h0000, 32'hA5A5_0F0F, 32'h0},          // R2 plain write reg0
    '{1'b0, 1'b1, 14'h0000, 32'h0,         32'hA5A5_0F0F},  // R2
    '{1'b1, 1'b0, 14'h1000, 32'hFFFF_0000, 32'h0},          // R3 flip reg0
    '{1'b0, 1'b1, 14'h1000, 32'h0,         32'h5A5A_0F0F},  // R3 read via flip window
    '{1'b1, 1'b0, 14'h2004, 32'h0000_00F0, 32'h0},          // R4 set reg1
    '{1'b1, 1'b0, 14'h2004, 32'h0F00_0000, 32'h0},          // R4
    '{1'b0, 1'b1, 14'h3004, 32'h0,         32'h0F00_00F0},  // R4 via clear window
    '{1'b0, 1'b1, 14'h0004, 32'h0,         32'h0F00_00F0},  // R6 no change
    '{1'b1, 1'b0, 14'h3004, 32'h0000_00F0, 32'h0},          // R5 clear reg1
    '{1'b0, 1'b1, 14'h2004, 32'h0,         32'h0F00_0000},  // R5
    '{1'b1, 1'b0, 14'h001C, 32'h1234_5678, 32'h0},          // R7 last reg
    '{1'b0, 1'b1, 14'h101C, 32'h0,         32'h1234_5678},  // R7
    '{1'b1, 1'b0, 14'h0020, 32'hDEAD_BEEF, 32'h0},          // R7 out of range
    '{1'b0, 1'b1, 14'h0020, 32'h0,         32'h0},          // R7
    '{1'b0, 1'b1, 14'h0000, 32'h0,         32'h5A5A_0F0F},  // R7 reg0 untouched
    '{1'b1, 1'b0, 14'h0007, 32'h0000_0011, 32'h0},          // R10 low bits set
    '{1'b0, 1'b1, 14'h0005, 32'h0,         32'h0000_0011}   // R10
  };
  localparam string TAGS [NV] = '{"R2","R2","R3","R3","R4","R4","R4","R6","R5","R5",
                                  "R7","R7","R7","R7","R7","R10","R10"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic rd, input logic [13:0] a,
                        input logic [31:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", {31'b0, bus_rvalid}, 32'h0);
    check("R1", bus_rdata, 32'h0);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      access(1'b0, 1'b1, 14'(i * 4), 32'h0);
      check("R1", bus_rdata, 32'h0);
    end
    idle();

    for (int v = 0; v < NV; v++) begin
      access(VECS[v].wr, VECS[v].rd, VECS[v].addr, VECS[v].wdata);
      if (VECS[v].rd) begin
        check(TAGS[v], bus_rdata, VECS[v].exp);
        check(TAGS[v], {31'b0, bus_rvalid}, 32'h1);
      end
    end

    // R8: idle cycle drops valid and holds data
    idle();
    @(posedge clk); #1;
    check("R8", {31'b0, bus_rvalid}, 32'h0);
    check("R8", bus_rdata, 32'h0000_0011);

    // R9: read and write in one cycle see the old value
    access(1'b1, 1'b1, 14'h1008, 32'h0000_00FF);
    check("R9", bus_rdata, 32'h0);
    // R9: back-to-back flips compose
    access(1'b1, 1'b0, 14'h1008, 32'h0000_0001);
    access(1'b1, 1'b0, 14'h1008, 32'h0000_0003);
    access(1'b0, 1'b1, 14'h0008, 32'h0);
    check("R9", bus_rdata, 32'h0000_00FD);

    // R1: reset in the middle of a run clears storage
    idle();
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1", {31'b0, bus_rvalid}, 32'h0);
    @(negedge clk); rst = 1'b0;
    access(1'b0, 1'b1, 14'h0000, 32'h0);
    check("R1", bus_rdata, 32'h0);
    idle();

    repeat (2) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule